// File: doc/BRIEF.md
# Wake Event and Host-Timeout Controller

This block receives wake requests from a frame-classification engine, each a one-cycle pulse carrying the number of the rule that matched. A request counts only while the power-state field from the control registers shows a power-down state. An accepted wake does four things. It raises a wake interrupt bit. It latches the rule number into a status output. It drives an active-low event pin low, if the pin enable was set when the wake arrived. It loads a host-timeout countdown from a programmed count.

The host clears the event by pulsing an acknowledge strobe. If the countdown runs out before that acknowledge arrives, the block emits a one-cycle request. That request asks for transmission of a prepared "host not responding" frame from its dedicated transmit queue. The wake stays pending after the timeout until the host acknowledges it.

Top module: `wake_timeout_ctrl`

## Requirements
- R1: After reset, `wake_irq` is 0, `evt_pin_n` is 1, `timeout_txreq` is 0 and `wake_status` is all zeros.
- R2: While `pwr_state` is 0, a `wake_req` pulse has no effect: `wake_irq`, `evt_pin_n`, `wake_status` and `timeout_txreq` keep their values.
- R3: A `wake_req` sampled at a clock edge, with `pwr_state` non-zero, no wake pending and `wake_ack` low, is accepted. `wake_irq` reads 1 from that edge onward.
- R4: On an accepted wake, `evt_pin_n` goes to 0 at the same edge if `evt_pin_en` was 1 at that edge. Otherwise it stays at 1. Later changes of `evt_pin_en` do not affect a pending event.
- R5: On an accepted wake, `wake_status` takes the value of `wake_rule` at the same edge. It holds that value until the next accepted wake.
- R6: Take N as `timeout_count` at the accepting edge, with a value of 0 treated as 1. With no acknowledge in between, `timeout_txreq` is 1 for exactly the one cycle that follows the N-th clock edge after the accepting edge.
- R7: A `wake_ack` sampled at an edge clears `wake_irq` to 0 and sets `evt_pin_n` to 1 at that edge. It also stops the countdown, so `timeout_txreq` is not raised at that edge or at any later edge for that wake.
- R8: A `wake_req` that arrives while a wake is pending is ignored. It does not reload the countdown or change `wake_status`.
- R9: `timeout_txreq` is raised at most once per accepted wake and is never high for two consecutive cycles. `wake_irq` stays 1 after the timeout until it is acknowledged.
- R10: When `wake_req` and `wake_ack` are both sampled high at the same edge, the acknowledge wins and the wake is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wake_req | input | 1 | One-cycle wake request from the classifier |
| wake_rule | input | RULE_W | Number of the rule that raised the request |
| pwr_state | input | PS_W | Power-state field; 0 means running, any other value is power-down |
| evt_pin_en | input | 1 | Enables the event pin for wakes accepted while it is 1 |
| wake_ack | input | 1 | Host acknowledge strobe |
| timeout_count | input | CNT_W | Countdown reload value |
| evt_pin_n | output | 1 | Power-management event pin, active low |
| wake_irq | output | 1 | Wake interrupt bit |
| wake_status | output | RULE_W | Captured rule number of the last accepted wake |
| timeout_txreq | output | 1 | One-cycle request to send the timeout frame |

## Verification
A corrupted pending flag would show on `wake_irq` at the next edge. It would also show later as a second wake being accepted and `wake_status` being overwritten. A countdown that is off by one moves the `timeout_txreq` pulse by a cycle, and the bench samples every cycle of the window, so that shows at once. A stuck fired flag shows as a missing or repeated timeout request. A latch that ignores the acknowledge leaves `wake_irq` or `evt_pin_n` asserted one cycle after the strobe.

// File: rtl/wake_timeout_ctrl.sv
module wake_timeout_ctrl #(
  parameter int RULE_W = 7,
  parameter int PS_W   = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_req,
  input  logic [RULE_W-1:0] wake_rule,
  input  logic [PS_W-1:0]   pwr_state,
  input  logic              evt_pin_en,
  input  logic              wake_ack,
  input  logic [CNT_W-1:0]  timeout_count,
  output logic              evt_pin_n,
  output logic              wake_irq,
  output logic [RULE_W-1:0] wake_status,
  output logic              timeout_txreq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             pending;
  logic             fired;
  logic [CNT_W-1:0] cnt;

  wire powered_down = |pwr_state;
  wire accept       = wake_req & powered_down & ~pending & ~wake_ack;
  wire expire       = pending & ~fired & ~wake_ack & (cnt <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending     <= 1'b0;
      wake_status <= '0;
      evt_pin_n   <= 1'b1;
    end else if (wake_ack) begin
      pending   <= 1'b0;
      evt_pin_n <= 1'b1;
    end else if (accept) begin
      pending     <= 1'b1;
      wake_status <= wake_rule;
      evt_pin_n   <= ~evt_pin_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (wake_ack)   cnt <= '0;
    else if (accept)     cnt <= timeout_count;
    else if (cnt != '0)  cnt <= cnt - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired         <= 1'b0;
      timeout_txreq <= 1'b0;
    end else begin
      timeout_txreq <= expire;
      if (wake_ack || accept) fired <= 1'b0;
      else if (expire)        fired <= 1'b1;
    end
  end

  assign wake_irq = pending;

  a_r2_idle_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == '0 && !wake_irq) |=> !wake_irq);

  a_r4_pin_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_pin_n |-> wake_irq);

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |=> (!wake_irq && evt_pin_n && !timeout_txreq));

  a_r5_status_held: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> $stable(wake_status));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_txreq |=> !timeout_txreq);

  a_r9_pulse_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_txreq |-> wake_irq);

  a_r6_countdown_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !wake_ack && !accept) |=> (cnt == $past(cnt) - ONE));

endmodule

// File: tb/sim_wake_timeout_ctrl.sv
module sim_wake_timeout_ctrl;
  localparam int RULE_W = 7;
  localparam int PS_W   = 2;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake_req = 1'b0;
  logic [RULE_W-1:0] wake_rule = '0;
  logic [PS_W-1:0] pwr_state = '0;
  logic evt_pin_en = 1'b0;
  logic wake_ack = 1'b0;
  logic [CNT_W-1:0] timeout_count = '0;
  logic evt_pin_n, wake_irq, timeout_txreq;
  logic [RULE_W-1:0] wake_status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wake_timeout_ctrl #(.RULE_W(RULE_W), .PS_W(PS_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .wake_rule(wake_rule),
    .pwr_state(pwr_state), .evt_pin_en(evt_pin_en), .wake_ack(wake_ack),
    .timeout_count(timeout_count), .evt_pin_n(evt_pin_n), .wake_irq(wake_irq),
    .wake_status(wake_status), .timeout_txreq(timeout_txreq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ps, pin_en, rule, count, ack_at (0 = never)
  typedef struct packed {
    logic [1:0]  ps;
    logic        en;
    logic [6:0]  rule;
    logic [15:0] cnt;
    logic [7:0]  ack_at;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{2'd1, 1'b1, 7'h10, 16'd3, 8'd0},
    '{2'd2, 1'b0, 7'h02, 16'd5, 8'd0},
    '{2'd0, 1'b1, 7'h33, 16'd4, 8'd0},
    '{2'd3, 1'b1, 7'h7F, 16'd0, 8'd0},
    '{2'd1, 1'b0, 7'h21, 16'd1, 8'd0},
    '{2'd1, 1'b1, 7'h44, 16'd6, 8'd3},
    '{2'd2, 1'b1, 7'h05, 16'd4, 8'd4},
    '{2'd3, 1'b0, 7'h0A, 16'd2, 8'd5}
  };

  task automatic scenario(input vec_t v);
    bit acc;
    int n;
    int prev_status;
    prev_status = wake_status;
    @(negedge clk);
    wake_req = 1'b1; wake_rule = v.rule; pwr_state = v.ps;
    evt_pin_en = v.en; timeout_count = v.cnt;
    @(negedge clk);
    wake_req = 1'b0;
    acc = (v.ps != 0);
    n = (v.cnt == 0) ? 1 : int'(v.cnt);
    chk(acc ? "R3 irq" : "R2 irq", wake_irq, acc);
    chk("R4 pin", evt_pin_n, !(acc && v.en));
    chk(acc ? "R5 status" : "R2 status", wake_status, acc ? int'(v.rule) : prev_status);
    evt_pin_en = ~v.en;
    for (int k = 1; k <= n + 3; k++) begin
      wake_ack = (k == int'(v.ack_at));
      @(negedge clk);
      chk("R6 txreq", timeout_txreq,
          acc && k == n && (v.ack_at == 0 || int'(v.ack_at) > n));
      chk("R9/R7 irq", wake_irq, acc && (v.ack_at == 0 || k < int'(v.ack_at)));
      chk("R4 pin held", evt_pin_n,
          !(acc && v.en && (v.ack_at == 0 || k < int'(v.ack_at))));
    end
    wake_ack = 1'b1;
    @(negedge clk);
    wake_ack = 1'b0;
    chk("R7 irq cleared", wake_irq, 0);
    chk("R7 pin released", evt_pin_n, 1);
    @(negedge clk);
    chk("R7 no late txreq", timeout_txreq, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R1 irq", wake_irq, 0);
    chk("R1 pin", evt_pin_n, 1);
    chk("R1 txreq", timeout_txreq, 0);
    chk("R1 status", wake_status, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) scenario(VT[i]);

    // R8: second wake while pending is ignored
    @(negedge clk);
    wake_req = 1'b1; wake_rule = 7'h05; pwr_state = 2'd1; timeout_count = 16'd6;
    evt_pin_en = 1'b0;
    @(negedge clk);
    wake_req = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      if (k == 2) begin
        wake_req = 1'b1; wake_rule = 7'h09; timeout_count = 16'd20;
      end else wake_req = 1'b0;
      @(negedge clk);
      chk("R8 txreq timing", timeout_txreq, k == 6);
      chk("R8 status kept", wake_status, 5);
    end
    chk("R9 irq after timeout", wake_irq, 1);
    wake_ack = 1'b1;
    @(negedge clk);
    wake_ack = 1'b0;
    chk("R7 irq cleared", wake_irq, 0);

    // R10: wake and ack at the same edge
    wake_req = 1'b1; wake_ack = 1'b1; wake_rule = 7'h11; timeout_count = 16'd2;
    @(negedge clk);
    wake_req = 1'b0; wake_ack = 1'b0;
    chk("R10 irq", wake_irq, 0);
    chk("R10 status", wake_status, 5);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk("R10 no txreq", timeout_txreq, 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule